// File: doc/BRIEF.md
# CRT Raster Timing Generator

This block produces the horizontal and vertical sync, blanking and display-enable signals for a character-based raster display. A character-clock enable advances a horizontal counter of 8-pixel character cells. Each horizontal wrap advances a scan-line counter. All timing values come from a flat CRT register image that a separate register interface drives. Several of the vertical values in that image are split across an overflow register and a second register, and the block puts them back together. Two bits of a miscellaneous-output byte select the polarity of each sync output.

Each of the four intervals (horizontal blank, horizontal sync, vertical blank, vertical sync) has its own two-state machine, with states SPAN_IDLE and SPAN_LIVE:
- The SPAN_IDLE to SPAN_LIVE transition happens when the counter's next value equals the full start value.
- The SPAN_LIVE to SPAN_IDLE transition happens when the low bits of the counter's next value equal the stored end field.
- Only one transition can happen per step, and the start test is made only in SPAN_IDLE.
- Horizontal machines step on every character enable. Vertical machines step only on a horizontal wrap.

The register image is 25 bytes. Byte n occupies bits [8n+7:8n].

Top module: `crt_raster_timer`

## Requirements
- R1: After reset, the character and line counters are 0, and the horizontal blank, vertical blank and raw sync states are inactive (sync pins equal their polarity bits).
- R2: The character counter advances only on a cycle with `char_en` high. After value byte0+4 it returns to 0, so the line period is byte0+5 characters.
- R3: The line counter advances only when the character counter wraps. Vertical total is the 10-bit value {byte7[5], byte7[0], byte6}. After value total+1 the line counter returns to 0.
- R4: `disp_en` is high exactly when the character count ≤ byte1 and the line count ≤ {byte7[6], byte7[1], byte18}.
- R5: Horizontal blank goes high when the next character count equals byte2. It goes low when the low 6 bits of the next count equal {byte5[7], byte3[4:0]}.
- R6: Raw horizontal sync goes high when the next character count equals byte4. It goes low when the low 5 bits of the next count equal byte5[4:0].
- R7: Vertical blank goes high when the next line equals {byte9[5], byte7[3], byte21}. It goes low when the low 8 bits of the next line equal byte22.
- R8: Vertical sync goes high when the next line equals {byte7[7], byte7[2], byte16}. It goes low when the low 4 bits of the next line equal byte17[3:0].
- R9: `hsync` is the raw horizontal sync inverted when `misc_ctl[6]` is 1. `vsync` is the raw vertical sync inverted when `misc_ctl[7]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_en | input | 1 | Character-clock enable |
| crt_regs | input | 200 | CRT register image, byte n at bits [8n+7:8n] |
| misc_ctl | input | 8 | Miscellaneous output byte; bits 6 and 7 select sync polarity |
| h_char | output | 9 | Current character count |
| v_line | output | 11 | Current line count |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| disp_en | output | 1 | Display enable |

## Verification
The bench sweeps four register images and compares every output on every cycle against an arithmetic frame model. Each image is run for more than one full frame.
- The first image is small and has no overflow bits set. It is run with `char_en` low on every third cycle, which separates an enable that holds the counters from one that is ignored.
- The second image uses a wide line and an end-of-blank field whose bit 5 is set. Blank then ends on the following line rather than early, which exposes a dropped high bit.
- The third and fourth images place vertical total, display end, sync start and blank start above 255 and above 511. This shows whether each overflow bit is routed to the right field.
- Across the images the polarity byte takes several values, which separates inverted from plain sync.

// File: rtl/crt_timing_pkg.sv
package crt_timing_pkg;
    localparam int REG_W     = 8;
    localparam int REG_COUNT = 25;
    localparam int IMG_W     = REG_W * REG_COUNT;
    localparam int HF_W      = 8;   // horizontal field width
    localparam int VF_W      = 10;  // vertical field width after overflow merge
    localparam int H_CNT_W   = HF_W + 1;
    localparam int V_CNT_W   = VF_W + 1;
    localparam int H_OFFSET  = 5;   // programmed total is count minus this
    localparam int V_OFFSET  = 2;

    typedef enum logic {
        SPAN_IDLE = 1'b0,
        SPAN_LIVE = 1'b1
    } span_state_t;

    typedef struct packed {
        logic [HF_W-1:0] h_total;
        logic [HF_W-1:0] h_disp_end;
        logic [HF_W-1:0] h_blank_start;
        logic [5:0]      h_blank_end;
        logic [HF_W-1:0] h_sync_start;
        logic [4:0]      h_sync_end;
        logic [VF_W-1:0] v_total;
        logic [VF_W-1:0] v_disp_end;
        logic [VF_W-1:0] v_sync_start;
        logic [3:0]      v_sync_end;
        logic [VF_W-1:0] v_blank_start;
        logic [7:0]      v_blank_end;
    } crt_timing_t;
endpackage

// File: rtl/crt_field_decode.sv
module crt_field_decode
    import crt_timing_pkg::*;
(
    input  logic [IMG_W-1:0] img,
    output crt_timing_t      tim
);
    logic [REG_W-1:0] rb [REG_COUNT];

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_bytes
        assign rb[g] = img[g*REG_W +: REG_W];
    end

    logic [REG_W-1:0] ovf;
    assign ovf = rb[7];

    always_comb begin
        tim               = '0;
        tim.h_total       = rb[0];
        tim.h_disp_end    = rb[1];
        tim.h_blank_start = rb[2];
        tim.h_blank_end   = {rb[5][7], rb[3][4:0]};
        tim.h_sync_start  = rb[4];
        tim.h_sync_end    = rb[5][4:0];
        tim.v_total       = {ovf[5], ovf[0], rb[6]};
        tim.v_disp_end    = {ovf[6], ovf[1], rb[18]};
        tim.v_sync_start  = {ovf[7], ovf[2], rb[16]};
        tim.v_sync_end    = rb[17][3:0];
        tim.v_blank_start = {rb[9][5], ovf[3], rb[21]};
        tim.v_blank_end   = rb[22];
    end

    logic unused_fields;
    assign unused_fields = ^{rb[3][7:5], rb[5][6:5], ovf[4], rb[8], rb[9][7:6],
                             rb[9][4:0], rb[10], rb[11], rb[12], rb[13], rb[14],
                             rb[15], rb[17][7:4], rb[19], rb[20], rb[23], rb[24]};
endmodule

// File: rtl/crt_raster_counter.sv
module crt_raster_counter
    import crt_timing_pkg::*;
#(
    parameter int HT_W = HF_W,
    parameter int VT_W = VF_W,
    parameter int H_W  = HT_W + 1,
    parameter int V_W  = VT_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            char_en,
    input  logic [HT_W-1:0] h_total,
    input  logic [VT_W-1:0] v_total,
    output logic [H_W-1:0]  h_cnt,
    output logic [V_W-1:0]  v_cnt,
    output logic [H_W-1:0]  h_nxt,
    output logic [V_W-1:0]  v_nxt,
    output logic            line_step
);
    logic [H_W-1:0] h_last;
    logic [V_W-1:0] v_last;
    logic           h_wrap;
    logic           v_wrap;

    assign h_last    = H_W'(h_total) + H_W'(H_OFFSET - 1);
    assign v_last    = V_W'(v_total) + V_W'(V_OFFSET - 1);
    assign h_wrap    = (h_cnt >= h_last);
    assign v_wrap    = (v_cnt >= v_last);
    assign line_step = char_en && h_wrap;

    always_comb begin
        h_nxt = h_cnt;
        v_nxt = v_cnt;
        if (char_en) begin
            h_nxt = h_wrap ? '0 : h_cnt + 1'b1;
        end
        if (line_step) begin
            v_nxt = v_wrap ? '0 : v_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else begin
            h_cnt <= h_nxt;
            v_cnt <= v_nxt;
        end
    end

    a_r2_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !char_en |=> $stable(h_cnt));
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (char_en && h_cnt >= h_last) |=> (h_cnt == '0));
    a_r3_line_only_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !(char_en && h_cnt >= h_last) |=> $stable(v_cnt));
endmodule

// File: rtl/crt_span_fsm.sv
module crt_span_fsm
    import crt_timing_pkg::*;
#(
    parameter int CNT_W   = H_CNT_W,
    parameter int START_W = HF_W,
    parameter int END_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic [CNT_W-1:0]   next_cnt,
    input  logic [START_W-1:0] start_at,
    input  logic [END_W-1:0]   end_at,
    output logic               active
);
    span_state_t state_q;
    span_state_t state_d;
    logic        hit_start;
    logic        hit_end;

    assign hit_start = (next_cnt == CNT_W'(start_at));
    assign hit_end   = (next_cnt[END_W-1:0] == end_at);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SPAN_IDLE: if (step && hit_start) state_d = SPAN_LIVE;
            SPAN_LIVE: if (step && hit_end)   state_d = SPAN_IDLE;
            default:   state_d = SPAN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SPAN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        active = (state_q == SPAN_LIVE);
    end

    // R5..R8 share this machine
    a_r5_span_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state_q));
    a_r5_span_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (step && state_q == SPAN_IDLE && next_cnt == CNT_W'(start_at)) |=> (state_q == SPAN_LIVE));
    a_r5_span_leave: assert property (@(posedge clk) disable iff (!rst_n)
        (step && state_q == SPAN_LIVE && next_cnt[END_W-1:0] == end_at) |=> (state_q == SPAN_IDLE));
endmodule

// File: rtl/crt_raster_timer.sv
module crt_raster_timer
    import crt_timing_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               char_en,
    input  logic [IMG_W-1:0]   crt_regs,
    input  logic [7:0]         misc_ctl,
    output logic [H_CNT_W-1:0] h_char,
    output logic [V_CNT_W-1:0] v_line,
    output logic               hsync,
    output logic               vsync,
    output logic               hblank,
    output logic               vblank,
    output logic               disp_en
);
    crt_timing_t        tim;
    logic [H_CNT_W-1:0] h_nxt;
    logic [V_CNT_W-1:0] v_nxt;
    logic               line_step;
    logic               hs_raw;
    logic               vs_raw;

    crt_field_decode u_decode (
        .img (crt_regs),
        .tim (tim)
    );

    crt_raster_counter #(.HT_W(HF_W), .VT_W(VF_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_en   (char_en),
        .h_total   (tim.h_total),
        .v_total   (tim.v_total),
        .h_cnt     (h_char),
        .v_cnt     (v_line),
        .h_nxt     (h_nxt),
        .v_nxt     (v_nxt),
        .line_step (line_step)
    );

    crt_span_fsm #(.CNT_W(H_CNT_W), .START_W(HF_W), .END_W(6)) u_hblank (
        .clk (clk), .rst_n (rst_n), .step (char_en), .next_cnt (h_nxt),
        .start_at (tim.h_blank_start), .end_at (tim.h_blank_end), .active (hblank)
    );

    crt_span_fsm #(.CNT_W(H_CNT_W), .START_W(HF_W), .END_W(5)) u_hsync (
        .clk (clk), .rst_n (rst_n), .step (char_en), .next_cnt (h_nxt),
        .start_at (tim.h_sync_start), .end_at (tim.h_sync_end), .active (hs_raw)
    );

    crt_span_fsm #(.CNT_W(V_CNT_W), .START_W(VF_W), .END_W(8)) u_vblank (
        .clk (clk), .rst_n (rst_n), .step (line_step), .next_cnt (v_nxt),
        .start_at (tim.v_blank_start), .end_at (tim.v_blank_end), .active (vblank)
    );

    crt_span_fsm #(.CNT_W(V_CNT_W), .START_W(VF_W), .END_W(4)) u_vsync (
        .clk (clk), .rst_n (rst_n), .step (line_step), .next_cnt (v_nxt),
        .start_at (tim.v_sync_start), .end_at (tim.v_sync_end), .active (vs_raw)
    );

    always_comb begin
        hsync   = hs_raw ^ misc_ctl[6];
        vsync   = vs_raw ^ misc_ctl[7];
        disp_en = (h_char <= H_CNT_W'(tim.h_disp_end)) &&
                  (v_line <= V_CNT_W'(tim.v_disp_end));
    end

    logic unused_misc;
    assign unused_misc = ^misc_ctl[5:0];

    a_r4_de_blank_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        (v_line > V_CNT_W'(tim.v_disp_end)) |-> !disp_en);
endmodule

// File: tb/test_crt_raster_timer.sv
module test_crt_raster_timer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         char_en = 1'b0;
    logic [199:0] crt_regs = '0;
    logic [7:0]   misc_ctl = '0;
    logic [8:0]   h_char;
    logic [10:0]  v_line;
    logic         hsync, vsync, hblank, vblank, disp_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int htot, hde, hbs, hbe, hss, hse, vt, vde, vss, vse, vbs, vbe;
    int mh, mv, mhb, mhs, mvb, mvs;

    always #4 clk = ~clk;

    crt_raster_timer i_crt_raster_timer (
        .clk(clk), .rst_n(rst_n), .char_en(char_en), .crt_regs(crt_regs),
        .misc_ctl(misc_ctl), .h_char(h_char), .v_line(v_line), .hsync(hsync),
        .vsync(vsync), .hblank(hblank), .vblank(vblank), .disp_en(disp_en)
    );

    function automatic int rb(int n);
        return int'(crt_regs[n*8 +: 8]);
    endfunction

    task automatic set_reg(int n, int v);
        crt_regs[n*8 +: 8] = v[7:0];
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at h=%0d v=%0d", tag, act, exp, mh, mv);
        end
    endtask

    task automatic decode_model();
        int o;
        o    = rb(7);
        htot = rb(0);
        hde  = rb(1);
        hbs  = rb(2);
        hbe  = (((rb(5) >> 7) & 1) << 5) | (rb(3) & 31);
        hss  = rb(4);
        hse  = rb(5) & 31;
        vt   = (((o >> 5) & 1) << 9) | ((o & 1) << 8) | rb(6);
        vde  = (((o >> 6) & 1) << 9) | (((o >> 1) & 1) << 8) | rb(18);
        vss  = (((o >> 7) & 1) << 9) | (((o >> 2) & 1) << 8) | rb(16);
        vse  = rb(17) & 15;
        vbs  = (((rb(9) >> 5) & 1) << 9) | (((o >> 3) & 1) << 8) | rb(21);
        vbe  = rb(22);
    endtask

    task automatic model_step();
        int hn, vn;
        bit wrap;
        wrap = (mh >= htot + 4);
        hn = wrap ? 0 : mh + 1;
        vn = wrap ? ((mv >= vt + 1) ? 0 : mv + 1) : mv;
        if (mhb == 0) begin if (hn == hbs) mhb = 1; end
        else if ((hn & 63) == hbe) mhb = 0;
        if (mhs == 0) begin if (hn == hss) mhs = 1; end
        else if ((hn & 31) == hse) mhs = 0;
        if (wrap) begin
            if (mvb == 0) begin if (vn == vbs) mvb = 1; end
            else if ((vn & 255) == vbe) mvb = 0;
            if (mvs == 0) begin if (vn == vss) mvs = 1; end
            else if ((vn & 15) == vse) mvs = 0;
        end
        mh = hn;
        mv = vn;
    endtask

    task automatic compare_all();
        chk("R2", int'(h_char), mh);
        chk("R3", int'(v_line), mv);
        chk("R4", int'(disp_en), int'(mh <= hde && mv <= vde));
        chk("R5", int'(hblank), mhb);
        chk(misc_ctl[6] ? "R9" : "R6", int'(hsync), mhs ^ int'(misc_ctl[6]));
        chk("R7", int'(vblank), mvb);
        chk(misc_ctl[7] ? "R9" : "R8", int'(vsync), mvs ^ int'(misc_ctl[7]));
    endtask

    task automatic run_config(int cycles, bit gaps);
        rst_n   = 1'b0;
        char_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        decode_model();
        mh = 0; mv = 0; mhb = 0; mhs = 0; mvb = 0; mvs = 0;
        @(negedge clk);
        // R1: reset state
        chk("R1", int'(h_char), 0);
        chk("R1", int'(v_line), 0);
        chk("R1", int'(hblank), 0);
        chk("R1", int'(vblank), 0);
        chk("R1", int'(hsync), int'(misc_ctl[6]));
        chk("R1", int'(vsync), int'(misc_ctl[7]));
        for (int i = 0; i < cycles; i++) begin
            bit en;
            if (i > 0) @(negedge clk);
            compare_all();
            en = gaps ? (i % 3 != 2) : 1'b1;
            char_en = en;
            if (en) model_step();
        end
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        // A: small frame, enable gaps
        crt_regs = '0; misc_ctl = 8'h00;
        set_reg(0, 5);  set_reg(1, 6);  set_reg(2, 7);  set_reg(3, 8'h01);
        set_reg(4, 8);  set_reg(5, 8'h03); set_reg(6, 10); set_reg(18, 8);
        set_reg(16, 9); set_reg(17, 8'h0B); set_reg(21, 9); set_reg(22, 11);
        run_config(450, 1'b1);

        // B: wide line, blank end bit 5 set, both syncs inverted
        crt_regs = '0; misc_ctl = 8'hC0;
        set_reg(0, 40); set_reg(1, 31); set_reg(2, 36); set_reg(3, 8'h01);
        set_reg(4, 34); set_reg(5, 8'h86); set_reg(6, 4); set_reg(18, 3);
        set_reg(16, 2); set_reg(17, 4); set_reg(21, 1); set_reg(22, 5);
        run_config(700, 1'b0);

        // C: bit-8 overflow fields
        crt_regs = '0; misc_ctl = 8'h80;
        set_reg(0, 1);  set_reg(1, 3);  set_reg(2, 4);  set_reg(3, 8'h05);
        set_reg(4, 2);  set_reg(5, 8'h04); set_reg(6, 8'h01); set_reg(7, 8'h0F);
        set_reg(18, 0); set_reg(16, 2); set_reg(17, 4); set_reg(21, 1); set_reg(22, 3);
        run_config(1700, 1'b0);

        // D: bit-9 overflow fields
        crt_regs = '0; misc_ctl = 8'h40;
        set_reg(0, 0);  set_reg(1, 2);  set_reg(2, 3);  set_reg(3, 8'h04);
        set_reg(4, 1);  set_reg(5, 8'h03); set_reg(6, 2); set_reg(7, 8'hE0);
        set_reg(18, 1); set_reg(16, 0); set_reg(17, 3); set_reg(9, 8'h20);
        set_reg(21, 5); set_reg(22, 8'h0A);
        run_config(2800, 1'b0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule